// File: doc/BRIEF.md
# Float-Integer Conversion Unit

This unit converts 32-bit operands between IEEE single-precision floats and 32-bit two's-complement or unsigned integers, in either direction. A two-bit mode picks the direction and the integer signedness. For the float-to-integer direction, a separate control bit picks between truncation toward zero and rounding to the nearest integer with halfway cases pushed away from zero. Every conversion, in every mode, takes exactly three clock cycles. A new operand may be accepted on every cycle.

Results that cannot be represented set an invalid flag and return a saturated value. Results that lost fraction bits set an inexact flag. Subnormal float operands are treated as their exact tiny values and are not flushed to zero. Integers wider than the 24-bit float significand are rounded to nearest, with ties going to the even significand.

Top module: `fcvt_unit`

## Requirements
- R1: An operand accepted with `in_valid` high at a rising edge produces `out_valid` high after exactly the third following rising edge, in every mode. Back-to-back operands are all delivered. When no operand was accepted, `out_valid` stays low.
- R2: Mode 2'b00 treats the operand as a signed integer and returns its float encoding (sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0). Integer zero gives 32'h0.
- R3: Mode 2'b01 treats the operand as an unsigned integer. Its results always have bit 31 clear.
- R4: In the integer-to-float modes, a magnitude needing more than 24 significant bits is rounded to nearest, with ties to an even significand, and `out_inexact` is raised. `out_invalid` is never raised in these modes.
- R5: Mode 2'b10 is float to signed integer and mode 2'b11 is float to unsigned integer. With `in_round_away` low, the float is truncated toward zero. `out_inexact` is raised when any fraction was discarded.
- R6: With `in_round_away` high, float-to-integer results round to nearest, and an exact half goes to the larger magnitude.
- R7: Subnormal float operands (exponent field zero) convert from their exact value: zero with `out_inexact` when the value is nonzero, in either rounding option.
- R8: Float to signed integer saturates to 32'h7FFFFFFF for positive values above 2^31-1 and for +infinity. It saturates to 32'h80000000 for negative values below -2^31 and for -infinity. Either case raises `out_invalid`. -2^31 itself converts exactly.
- R9: Float to unsigned integer saturates to 32'hFFFFFFFF for values at or above 2^32 and for +infinity, raising `out_invalid`.
- R10: A NaN operand in a float-to-integer mode returns 32'h7FFFFFFF for signed and 32'hFFFFFFFF for unsigned, and raises `out_invalid`.
- R11: In mode 2'b11, a negative operand returns 0. It raises `out_invalid` if its rounded magnitude is nonzero. Otherwise it raises only `out_inexact`, and only when a fraction was discarded.
- R12: `out_invalid` and `out_inexact` are never high together. `in_round_away` has no effect on integer-to-float results.
- R13: While `rst_n` is low, `out_valid`, `out_result` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 2 | Conversion mode: bit 1 set = float to integer, bit 0 set = unsigned integer |
| in_round_away | input | 1 | Float-to-integer rounding: 0 truncates, 1 rounds half away from zero |
| in_operand | input | 32 | Integer or float operand |
| out_valid | output | 1 | Result strobe, three cycles after the operand |
| out_result | output | 32 | Converted value |
| out_invalid | output | 1 | Result saturated or NaN operand |
| out_inexact | output | 1 | Fraction bits were lost |

## Verification
The hardest outcomes to reach from the ports are exact ties. These are an integer exactly halfway between two representable floats, and a float with a fraction of exactly one half. Random operands almost never produce them. They are placed directly: 2^24+1 and 2^24+3 for the even-tie choice, and ±0.5, ±2.5 and -0.6 under both rounding options. The edges of the saturation ranges are reached the same way, using floats adjacent to 2^31, -2^31 and 2^32. A large random run is then biased so that float exponents cluster around the integer range, and it mixes all four modes with idle gaps. Each result is compared against a real-arithmetic model.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int INT_W = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int SIG_W = MAN_W + 1;
    localparam int BIAS  = 127;

    typedef enum logic [1:0] {
        CVT_I2F_S = 2'b00,
        CVT_I2F_U = 2'b01,
        CVT_F2I_S = 2'b10,
        CVT_F2I_U = 2'b11
    } cvt_mode_e;

    typedef struct packed {
        logic             vld;
        cvt_mode_e        mode;
        logic             away;
        logic [INT_W-1:0] opnd;
    } in_stage_t;

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] res;
        logic             inv;
        logic             inx;
    } out_stage_t;

    typedef struct packed {
        in_stage_t  s1;
        out_stage_t s2;
        out_stage_t s3;
    } pipe_t;
endpackage

// File: rtl/fcvt_int_to_flt.sv
module fcvt_int_to_flt
    import fcvt_pkg::*;
(
    input  logic [INT_W-1:0] opnd,
    input  logic             is_signed,
    output logic [INT_W-1:0] res,
    output logic             inexact
);
    localparam int LZ_W    = $clog2(INT_W);
    localparam int GRD_IDX = INT_W - 2 - MAN_W;
    localparam int EM_W    = EXP_W + MAN_W;

    logic             neg;
    logic             found;
    logic [LZ_W-1:0]  lz;
    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] norm;
    logic             grd;
    logic             stk;
    logic             up;
    logic [EM_W-1:0]  em_raw;
    logic [EM_W-1:0]  em_rnd;

    always_comb begin
        neg   = is_signed & opnd[INT_W-1];
        mag   = neg ? (~opnd + 1'b1) : opnd;
        // leading-one search from the top bit downwards
        lz    = '0;
        found = 1'b0;
        for (int i = INT_W - 1; i >= 0; i--) begin
            if (!found && mag[i]) begin
                lz    = LZ_W'(INT_W - 1 - i);
                found = 1'b1;
            end
        end
        norm   = mag << lz;
        grd    = norm[GRD_IDX];
        stk    = |norm[GRD_IDX-1:0];
        up     = grd & (stk | norm[GRD_IDX+1]);
        em_raw = {EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz), norm[INT_W-2 -: MAN_W]};
        // a carry out of the fraction bumps the exponent on its own
        em_rnd = em_raw + EM_W'(up);
        if (!found) begin
            res     = '0;
            inexact = 1'b0;
        end else begin
            res     = {neg, em_rnd};
            inexact = grd | stk;
        end
    end
endmodule

// File: rtl/fcvt_flt_to_int.sv
module fcvt_flt_to_int
    import fcvt_pkg::*;
(
    input  logic [INT_W-1:0] opnd,
    input  logic             is_signed,
    input  logic             away,
    output logic [INT_W-1:0] res,
    output logic             invalid,
    output logic             inexact
);
    localparam int UNIT_POS = BIAS + MAN_W;       // exponent whose LSB weighs 1
    localparam int BIG_W    = 2 * INT_W;
    localparam int LSH_MAX  = BIG_W - SIG_W;
    localparam int RSH_MAX  = SIG_W + 2;
    localparam int EXT_W    = SIG_W + RSH_MAX;

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] fr;
    logic [SIG_W-1:0] sig;
    logic [EXP_W:0]   eff;
    logic [EXP_W:0]   lsh;
    logic [EXP_W:0]   rsh;
    logic [EXT_W-1:0] ext;
    logic [BIG_W-1:0] whole;
    logic [BIG_W-1:0] mag;
    logic [INT_W-1:0] sat;
    logic             nan_in;
    logic             huge;
    logic             grd;
    logic             stk;

    always_comb begin
        sgn    = opnd[INT_W-1];
        ex     = opnd[INT_W-2 -: EXP_W];
        fr     = opnd[MAN_W-1:0];
        sig    = {ex != '0, fr};
        eff    = (ex == '0) ? (EXP_W+1)'(1) : {1'b0, ex};
        nan_in = (&ex) & (|fr);
        huge   = (&ex) || (eff > (EXP_W+1)'(UNIT_POS + LSH_MAX));
        lsh    = eff - (EXP_W+1)'(UNIT_POS);
        rsh    = (EXP_W+1)'(UNIT_POS) - eff;
        if (rsh > (EXP_W+1)'(RSH_MAX)) rsh = (EXP_W+1)'(RSH_MAX);
        ext    = '0;
        whole  = '0;
        grd    = 1'b0;
        stk    = 1'b0;
        if (eff >= (EXP_W+1)'(UNIT_POS)) begin
            whole = BIG_W'(sig) << lsh;
        end else begin
            ext   = {sig, {RSH_MAX{1'b0}}} >> rsh;
            whole = BIG_W'(ext[EXT_W-1 -: SIG_W]);
            grd   = ext[RSH_MAX-1];
            stk   = |ext[RSH_MAX-2:0];
        end
        mag = whole + BIG_W'(away & grd);
        // the saturation value doubles as the largest magnitude allowed
        if (is_signed) sat = {sgn, {(INT_W-1){~sgn}}};
        else           sat = {INT_W{~sgn}};

        res     = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        if (nan_in) begin
            invalid = 1'b1;
            res     = is_signed ? {1'b0, {(INT_W-1){1'b1}}} : {INT_W{1'b1}};
        end else if (huge || (mag > BIG_W'(sat))) begin
            invalid = 1'b1;
            res     = sat;
        end else begin
            res     = sgn ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
            inexact = grd | stk;
        end
    end
endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
    import fcvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_mode,
    input  logic             in_round_away,
    input  logic [INT_W-1:0] in_operand,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic             out_invalid,
    output logic             out_inexact
);
    pipe_t            pipe_d;
    pipe_t            pipe_q;
    logic [INT_W-1:0] i2f_res;
    logic             i2f_inx;
    logic [INT_W-1:0] f2i_res;
    logic             f2i_inv;
    logic             f2i_inx;

    fcvt_int_to_flt i2f_i (
        .opnd      (pipe_q.s1.opnd),
        .is_signed (~pipe_q.s1.mode[0]),
        .res       (i2f_res),
        .inexact   (i2f_inx)
    );

    fcvt_flt_to_int f2i_i (
        .opnd      (pipe_q.s1.opnd),
        .is_signed (~pipe_q.s1.mode[0]),
        .away      (pipe_q.s1.away),
        .res       (f2i_res),
        .invalid   (f2i_inv),
        .inexact   (f2i_inx)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1.vld  = in_valid;
        pipe_d.s1.mode = cvt_mode_e'(in_mode);
        pipe_d.s1.away = in_round_away;
        pipe_d.s1.opnd = in_operand;
        pipe_d.s2.vld  = pipe_q.s1.vld;
        if (pipe_q.s1.mode[1]) begin
            pipe_d.s2.res = f2i_res;
            pipe_d.s2.inv = f2i_inv;
            pipe_d.s2.inx = f2i_inx;
        end else begin
            pipe_d.s2.res = i2f_res;
            pipe_d.s2.inv = 1'b0;
            pipe_d.s2.inx = i2f_inx;
        end
        pipe_d.s3 = pipe_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid   = pipe_q.s3.vld;
    assign out_result  = pipe_q.s3.res;
    assign out_invalid = pipe_q.s3.inv;
    assign out_inexact = pipe_q.s3.inx;
endmodule

// File: rtl/fcvt_unit_sva.sv
module fcvt_unit_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  in_mode,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_invalid,
    input logic        out_inexact
);
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    assert_unsigned_positive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_mode, 3) == 2'b01) |-> !out_result[31]);

    assert_i2f_never_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_mode[1], 3)) |-> !out_invalid);

    assert_signed_saturation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid && $past(in_mode, 3) == 2'b10)
        |-> (out_result == 32'h7FFF_FFFF || out_result == 32'h8000_0000));

    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
endmodule

bind fcvt_unit fcvt_unit_sva sva_i (.*);

// File: tb/fcvt_unit_tb_top.sv
module fcvt_unit_tb_top;
    localparam real CLK_P = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic        in_round_away = 1'b0;
    logic [31:0] in_operand = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_inexact;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    int          q_due[$];
    logic [31:0] q_res[$];
    bit          q_inv[$];
    bit          q_inx[$];
    string       q_tag[$];

    fcvt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_round_away(in_round_away), .in_operand(in_operand),
        .out_valid(out_valid), .out_result(out_result),
        .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    always #(CLK_P / 2.0) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic model_i2f(input logic [31:0] a, input bit sgn,
                             output logic [31:0] r, output bit inx);
        longint m, q, rem, half;
        int sh;
        bit neg;
        neg = sgn && a[31];
        m = neg ? (64'h1_0000_0000 - longint'(a)) : longint'(a);
        inx = 1'b0;
        if (m == 0) begin
            r = '0;
            return;
        end
        q = m;
        sh = 0;
        while (q >= 64'd16777216) begin
            q = q >> 1;
            sh++;
        end
        if (sh > 0) begin
            rem  = m - (q << sh);
            half = 64'd1 << (sh - 1);
            if (rem > half || (rem == half && q[0])) q++;
            inx = (rem != 0);
            if (q == 64'd16777216) begin
                q = q >> 1;
                sh++;
            end
        end
        while (q < 64'd8388608) begin
            q = q << 1;
            sh--;
        end
        r = {neg, 8'(150 + sh), q[22:0]};
    endtask

    task automatic model_f2i(input logic [31:0] a, input bit sgn, input bit away,
                             output logic [31:0] r, output bit inv, output bit inx);
        int e, f, ee;
        real v, ip, fp, lim;
        longint mag;
        bit neg;
        e = int'(a[30:23]);
        f = int'(a[22:0]);
        neg = a[31];
        inv = 1'b0;
        inx = 1'b0;
        if (e == 255 && f != 0) begin
            inv = 1'b1;
            r = sgn ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
            return;
        end
        if (sgn) lim = neg ? 2147483648.0 : 2147483647.0;
        else     lim = neg ? 0.0 : 4294967295.0;
        if (e == 255) begin
            inv = 1'b1;
            r = sgn ? (neg ? 32'h8000_0000 : 32'h7FFF_FFFF) : (neg ? 32'h0 : 32'hFFFF_FFFF);
            return;
        end
        ee = (e == 0) ? 1 : e;
        v  = real'((e == 0) ? f : f + 8388608) * (2.0 ** (ee - 150));
        ip = $floor(v);
        fp = v - ip;
        if (away && fp >= 0.5) ip = ip + 1.0;
        if (ip > lim) begin
            inv = 1'b1;
            r = sgn ? (neg ? 32'h8000_0000 : 32'h7FFF_FFFF) : (neg ? 32'h0 : 32'hFFFF_FFFF);
            return;
        end
        mag = longint'(ip);
        r = neg ? 32'(-mag) : 32'(mag);
        inx = (fp != 0.0);
    endtask

    task automatic send(input logic [1:0] mode, input bit away, input logic [31:0] op,
                        input string tag);
        logic [31:0] r;
        bit inv, inx;
        @(negedge clk);
        in_valid      = 1'b1;
        in_mode       = mode;
        in_round_away = away;
        in_operand    = op;
        if (!mode[1]) begin
            model_i2f(op, !mode[0], r, inx);
            inv = 1'b0;
        end else begin
            model_f2i(op, !mode[0], away, r, inv, inx);
        end
        q_due.push_back(cyc + 3);
        q_res.push_back(r);
        q_inv.push_back(inv);
        q_inx.push_back(inx);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_operand = 32'hDEAD_BEEF;
        end
    endtask

    // compare every cycle a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK_P / 4.0);
        if (rst_n && !done) begin
            n_chk++;
            if (q_due.size() != 0 && q_due[0] == cyc) begin
                if (!out_valid || out_result !== q_res[0] ||
                    out_invalid !== q_inv[0] || out_inexact !== q_inx[0]) begin
                    n_bad++;
                    $display("FAIL %s: actual v=%b r=%h inv=%b inx=%b expected v=1 r=%h inv=%b inx=%b",
                             q_tag[0], out_valid, out_result, out_invalid, out_inexact,
                             q_res[0], q_inv[0], q_inx[0]);
                end
                void'(q_due.pop_front());
                void'(q_res.pop_front());
                void'(q_inv.pop_front());
                void'(q_inx.pop_front());
                void'(q_tag.pop_front());
            end else if (out_valid !== 1'b0) begin
                n_bad++;
                $display("FAIL R1: actual out_valid=%b expected out_valid=0", out_valid);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1: actual watchdog expired expected run to complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] op;
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_result !== 32'h0 || out_invalid !== 1'b0 ||
            out_inexact !== 1'b0) begin
            n_bad++;
            $display("FAIL R13: actual v=%b r=%h inv=%b inx=%b expected all zero",
                     out_valid, out_result, out_invalid, out_inexact);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2 signed integer to float
        send(2'b00, 0, 32'h0000_0000, "R2");
        send(2'b00, 0, 32'h0000_0001, "R2");
        send(2'b00, 0, 32'hFFFF_FFFF, "R2");
        send(2'b00, 0, 32'h8000_0000, "R2");
        send(2'b00, 0, 32'd12345, "R2");
        send(2'b00, 0, 32'h7FFF_FFFF, "R4");
        // R3 unsigned integer to float
        send(2'b01, 0, 32'hFFFF_FFFF, "R3");
        send(2'b01, 0, 32'h8000_0000, "R3");
        // R4 ties to even on the significand
        send(2'b01, 0, 32'h0100_0001, "R4");
        send(2'b01, 0, 32'h0100_0003, "R4");
        send(2'b00, 0, 32'h00FF_FFFF, "R4");
        // R12 rounding control ignored for integer to float
        send(2'b00, 1, 32'h0100_0003, "R12");
        send(2'b01, 1, 32'h0100_0001, "R12");
        idle(1);
        // R5 truncation
        send(2'b10, 0, 32'h406C_CCCD, "R5");
        send(2'b10, 0, 32'hC06C_CCCD, "R5");
        send(2'b11, 0, 32'h3F80_0000, "R5");
        send(2'b10, 0, 32'h4020_0000, "R5");
        // R6 half away from zero
        send(2'b10, 1, 32'h4020_0000, "R6");
        send(2'b10, 1, 32'hC020_0000, "R6");
        send(2'b11, 1, 32'h3F00_0000, "R6");
        send(2'b10, 1, 32'h4019_999A, "R6");
        // R7 subnormals kept exact
        send(2'b10, 0, 32'h0000_0001, "R7");
        send(2'b10, 1, 32'h007F_FFFF, "R7");
        send(2'b10, 1, 32'h8040_0000, "R7");
        // R8 signed saturation
        send(2'b10, 0, 32'h4F00_0000, "R8");
        send(2'b10, 0, 32'hCF00_0000, "R8");
        send(2'b10, 0, 32'hCF00_0001, "R8");
        send(2'b10, 1, 32'h7F80_0000, "R8");
        send(2'b10, 0, 32'hFF80_0000, "R8");
        // R9 unsigned saturation
        send(2'b11, 0, 32'h4F80_0000, "R9");
        send(2'b11, 0, 32'h4F7F_FFFF, "R9");
        send(2'b11, 0, 32'h7F80_0000, "R9");
        // R10 NaN
        send(2'b10, 0, 32'h7FC0_0000, "R10");
        send(2'b11, 1, 32'hFFC0_0001, "R10");
        // R11 negatives into unsigned
        send(2'b11, 0, 32'hBF80_0000, "R11");
        send(2'b11, 1, 32'hBECC_CCCD, "R11");
        send(2'b11, 1, 32'hBF19_999A, "R11");
        send(2'b11, 0, 32'hBF19_999A, "R11");
        send(2'b11, 0, 32'h8000_0000, "R11");
        send(2'b11, 0, 32'hFF80_0000, "R11");
        idle(4);

        // random mix, float exponents biased towards the integer range
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 3));
            op = $urandom;
            if (md[1] && ($urandom_range(0, 3) != 0))
                op[30:23] = 8'($urandom_range(110, 162));
            send(md, 1'($urandom_range(0, 1)), op, md[1] ? "R5" : "R2");
            if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(6);
        done = 1'b1;
        if (q_due.size() != 0) begin
            n_bad++;
            $display("FAIL R1: actual %0d results missing expected 0", q_due.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule